// File: doc/BRIEF.md
# Page-Buffered Non-Volatile Write Commit Engine

This block sits behind a serial-memory protocol engine. During a write transaction it gathers data bytes into a small page buffer. The buffer covers one page of the storage array. When the transaction ends, the block copies the gathered bytes into the array in a single write cycle of fixed length. It raises `busy` for the whole of that cycle. The protocol engine opens a transaction with `load_start`, which carries a page number and a starting byte offset. Each data byte arrives as a `byte_valid` pulse. The transaction ends with either a `commit` pulse (bus STOP) or an `abort` pulse. Reads of the array use a one-cycle registered port.

A per-offset mask records which buffer slots were loaded, and the commit stores only those slots. Each new byte goes to the current offset, and the offset then steps forward. It wraps inside the page, so a long burst overwrites earlier bytes of the same transaction. The array is cleared to FFh at reset. A single-byte write is the same operation as a page write with one byte loaded. `WRITE_CYCLES` must be at least `PAGE_BYTES`, and `PAGE_BYTES` and `NUM_PAGES` must be powers of two.

Top module: `page_commit_engine`

## Requirements
- R1: After reset, `busy` and `rd_valid` are low and every array address reads back as FFh.
- R2: `load_start` latches the page and starting offset. Each accepted byte goes to the current offset, and the offset then increments, wrapping from PAGE_BYTES-1 to 0 within the latched page.
- R3: A byte loaded at an offset that already holds a byte from the same transaction replaces the earlier value.
- R4: A `commit` pulse with at least one byte loaded raises `busy` on the next cycle. `busy` stays high for exactly WRITE_CYCLES cycles.
- R5: The commit writes each loaded offset of the latched page with its last loaded byte. All other addresses keep their previous contents.
- R6: An `abort` pulse, or a `commit` pulse with no byte loaded, empties the buffer and does not raise `busy`.
- R7: While `busy` is high, `load_start`, `byte_valid`, `abort` and `commit` have no effect. The commit in progress completes unchanged.
- R8: When `busy` is low, an `rd_en` pulse gives `rd_valid` high on the next cycle. `rd_data` then holds the byte at `rd_addr`, where the address is page*PAGE_BYTES + offset.
- R9: An `rd_en` pulse while `busy` is high gives no `rd_valid`.
- R10: When a commit completes, the buffer is empty, so a following `commit` with no new bytes does not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_start | input | 1 | Opens a transaction; latches page and offset |
| load_page | input | log2(NUM_PAGES) | Page number of the transaction |
| load_offset | input | log2(PAGE_BYTES) | Starting byte offset within the page |
| byte_valid | input | 1 | Strobe for one data byte |
| byte_data | input | 8 | Data byte |
| commit | input | 1 | Ends the transaction and starts the write cycle |
| abort | input | 1 | Discards the buffered bytes |
| busy | output | 1 | High during the write cycle |
| rd_en | input | 1 | Read request |
| rd_addr | input | log2(PAGE_BYTES*NUM_PAGES) | Read byte address |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted request |
| rd_data | output | 8 | Read data |

## Verification
A mask bit that is wrong or stale changes which bytes the commit stores. A mis-stepped offset has a similar effect on where bytes land. Either fault shows up at the ports only when the affected address is read after `busy` falls, so every commit in the bench is followed by a read of the whole array. A wrong write-cycle counter shows within one commit as a `busy` window of the wrong length. A wrong page-erased flag shows as FFh in place of stored data, or stored data in place of FFh, on the first read of that page.

// File: rtl/pce_pkg.sv
package pce_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/pce_page_buffer.sv
module pce_page_buffer
  import pce_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int PAGE_W     = 7,
  parameter int OFF_W      = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frozen,
  input  logic                 clear,
  input  logic                 load_start,
  input  logic [PAGE_W-1:0]    load_page,
  input  logic [OFF_W-1:0]     load_offset,
  input  logic                 byte_valid,
  input  logic [BYTE_W-1:0]    byte_data,
  input  logic [OFF_W-1:0]     rd_idx,
  output logic [PAGE_W-1:0]    page_q,
  output logic [PAGE_BYTES-1:0] mask_q,
  output logic [BYTE_W-1:0]    rd_byte,
  output logic                 rd_loaded
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);

  logic [BYTE_W-1:0] slot [PAGE_BYTES];
  logic [OFF_W-1:0]  off_q;
  logic              take_byte;

  assign take_byte = !frozen && !clear && !load_start && byte_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      off_q  <= '0;
      mask_q <= '0;
    end else if (clear) begin
      mask_q <= '0;
    end else if (!frozen) begin
      if (load_start) begin
        page_q <= load_page;
        off_q  <= load_offset;
        mask_q <= '0;
      end else if (byte_valid) begin
        mask_q[off_q] <= 1'b1;
        off_q         <= off_q + OFF_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take_byte) slot[off_q] <= byte_data;
  end

  assign rd_byte   = slot[rd_idx];
  assign rd_loaded = mask_q[rd_idx];

  AST_OFFSET_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (take_byte && off_q == LAST_OFF) |=> (off_q == '0)); // R2
  AST_FROZEN_MASK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (frozen && !clear) |=> $stable(mask_q)); // R7
endmodule

// File: rtl/pce_commit_ctrl.sv
module pce_commit_ctrl #(
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 1000,
  parameter int OFF_W        = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic             abort,
  input  logic             any_loaded,
  input  logic             slot_loaded,
  input  logic             page_fresh,
  output logic             busy,
  output logic [OFF_W-1:0] widx,
  output logic             wr_en,
  output logic             mark_en,
  output logic             clear,
  output logic             frozen
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WRITE_CYCLES - 1);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             walk_done_q;
  logic             walking;
  logic             done;

  assign walking = busy && !walk_done_q;
  assign done    = busy && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      cnt_q       <= '0;
      widx        <= '0;
      walk_done_q <= 1'b0;
    end else if (!busy) begin
      if (commit && any_loaded) begin
        busy        <= 1'b1;
        cnt_q       <= CNT_LOAD;
        widx        <= '0;
        walk_done_q <= 1'b0;
      end
    end else begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - CNT_W'(1);
      if (!walk_done_q) begin
        widx <= widx + OFF_W'(1);
        if (widx == LAST_OFF) walk_done_q <= 1'b1;
      end
    end
  end

  assign wr_en   = walking && (slot_loaded || page_fresh);
  assign mark_en = walking && (widx == LAST_OFF);
  assign clear   = done || (!busy && (abort || (commit && !any_loaded)));
  assign frozen  = busy || commit;

  AST_BURN_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(any_loaded)); // R6
  AST_BURN_FROM_COMMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(commit)); // R4
endmodule

// File: rtl/pce_store_array.sv
module pce_store_array
  import pce_pkg::*;
#(
  parameter int DEPTH     = 4096,
  parameter int ADDR_W    = 12,
  parameter int NUM_PAGES = 128,
  parameter int PAGE_W    = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              mark_en,
  input  logic [PAGE_W-1:0] cmt_page,
  output logic              cmt_fresh,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0]    mem [DEPTH];
  logic [NUM_PAGES-1:0] written_q;
  logic [BYTE_W-1:0]    mem_q;
  logic                 fresh_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) mem_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written_q <= '0;
      fresh_q   <= 1'b1;
    end else begin
      if (mark_en) written_q[cmt_page] <= 1'b1;
      if (rd_en)   fresh_q <= !written_q[rd_addr[ADDR_W-1 -: PAGE_W]];
    end
  end

  assign cmt_fresh = !written_q[cmt_page];
  assign rd_data   = fresh_q ? ERASED_BYTE : mem_q;
endmodule

// File: rtl/page_commit_engine.sv
module page_commit_engine
  import pce_pkg::*;
#(
  parameter int PAGE_BYTES   = 32,
  parameter int NUM_PAGES    = 128,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     load_start,
  input  logic [$clog2(NUM_PAGES)-1:0]             load_page,
  input  logic [$clog2(PAGE_BYTES)-1:0]            load_offset,
  input  logic                                     byte_valid,
  input  logic [7:0]                               byte_data,
  input  logic                                     commit,
  input  logic                                     abort,
  output logic                                     busy,
  input  logic                                     rd_en,
  input  logic [$clog2(PAGE_BYTES*NUM_PAGES)-1:0]  rd_addr,
  output logic                                     rd_valid,
  output logic [7:0]                               rd_data
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = $clog2(NUM_PAGES);
  localparam int DEPTH  = PAGE_BYTES * NUM_PAGES;
  localparam int ADDR_W = $clog2(DEPTH);

  logic                  frozen, clear, wr_en, mark_en, page_fresh;
  logic                  slot_loaded, rd_go;
  logic [OFF_W-1:0]      widx;
  logic [PAGE_W-1:0]     page_q;
  logic [PAGE_BYTES-1:0] mask_q;
  logic [BYTE_W-1:0]     slot_byte, wr_data;

  pce_page_buffer #(.PAGE_BYTES(PAGE_BYTES), .PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_buf (
    .clk(clk), .rst(rst), .frozen(frozen), .clear(clear),
    .load_start(load_start), .load_page(load_page), .load_offset(load_offset),
    .byte_valid(byte_valid), .byte_data(byte_data), .rd_idx(widx),
    .page_q(page_q), .mask_q(mask_q), .rd_byte(slot_byte), .rd_loaded(slot_loaded)
  );

  pce_commit_ctrl #(.PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES), .OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rst(rst), .commit(commit), .abort(abort), .any_loaded(|mask_q),
    .slot_loaded(slot_loaded), .page_fresh(page_fresh), .busy(busy), .widx(widx),
    .wr_en(wr_en), .mark_en(mark_en), .clear(clear), .frozen(frozen)
  );

  assign wr_data = slot_loaded ? slot_byte : ERASED_BYTE;
  assign rd_go   = rd_en && !busy;

  pce_store_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .NUM_PAGES(NUM_PAGES), .PAGE_W(PAGE_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr({page_q, widx}), .wr_data(wr_data),
    .mark_en(mark_en), .cmt_page(page_q), .cmt_fresh(page_fresh),
    .rd_en(rd_go), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_go;
  end

  AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> !rd_valid); // R9
  AST_WRITE_INSIDE_BURN: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> busy); // R4
  AST_BUFFER_EMPTY_AFTER_BURN: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (mask_q == '0)); // R10
  AST_READ_ONLY_WHEN_ASKED: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en)); // R8
endmodule

// File: tb/page_commit_engine_bench.sv
module page_commit_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PB = 8;
  localparam int NP = 8;
  localparam int WC = 16;
  localparam int DEPTH = PB * NP;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_start = 1'b0;
  logic [2:0] load_page = '0;
  logic [2:0] load_offset = '0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic       commit = 1'b0;
  logic       abort = 1'b0;
  logic       busy;
  logic       rd_en = 1'b0;
  logic [5:0] rd_addr = '0;
  logic       rd_valid;
  logic [7:0] rd_data;

  int checks = 0;
  int fails = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] eb [PB];
  logic       em [PB];

  page_commit_engine #(.PAGE_BYTES(PB), .NUM_PAGES(NP), .WRITE_CYCLES(WC)) u_page_commit_engine (
    .clk(clk), .rst(rst), .load_start(load_start), .load_page(load_page),
    .load_offset(load_offset), .byte_valid(byte_valid), .byte_data(byte_data),
    .commit(commit), .abort(abort), .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_chk(input int a, input string req);
    @(negedge clk); rd_en = 1'b1; rd_addr = 6'(a);
    @(negedge clk); rd_en = 1'b0;
    chk(rd_valid === 1'b1, {req, " rd_valid"}, int'(rd_valid), 1);
    chk(rd_data === model[a], {req, " rd_data"}, int'(rd_data), int'(model[a]));
  endtask

  task automatic sweep_all(input string req);
    for (int a = 0; a < DEPTH; a++) read_chk(a, req);
  endtask

  task automatic load_bytes(input int p, input int s, input int n, input int seed);
    for (int o = 0; o < PB; o++) em[o] = 1'b0;
    @(negedge clk); load_start = 1'b1; load_page = 3'(p); load_offset = 3'(s);
    @(negedge clk); load_start = 1'b0;
    for (int k = 0; k < n; k++) begin
      byte_valid = 1'b1;
      byte_data = 8'((seed * 37 + k * 13 + p * 5 + 1) & 8'hFF);
      eb[(s + k) % PB] = byte_data;
      em[(s + k) % PB] = 1'b1;
      @(negedge clk);
    end
    byte_valid = 1'b0;
  endtask

  task automatic pulse_commit_expect_burn(input int p, input string req);
    int len;
    commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    len = 0;
    while (busy === 1'b1 && len < 1000) begin len++; @(negedge clk); end
    chk(len == WC, req, len, WC);
    for (int o = 0; o < PB; o++) if (em[o]) model[p * PB + o] = eb[o];
  endtask

  task automatic expect_idle(input int cycles, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (busy !== 1'b0) seen = 1'b1;
    end
    chk(!seen, req, int'(seen), 0);
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state and erased contents
    chk(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(rd_valid === 1'b0, "R1 rd_valid after reset", int'(rd_valid), 0);
    sweep_all("R1");

    // R2 R3 R4 R5 R8: one byte, full page, and wrapping bursts on every page
    for (int p = 0; p < NP; p++) begin
      for (int v = 0; v < 3; v++) begin
        int n = (v == 0) ? 1 : (v == 1) ? PB : PB + 3;
        int s = (p * 3 + v * 5) % PB;
        load_bytes(p, s, n, p * 3 + v);
        pulse_commit_expect_burn(p, "R4 busy length");
        sweep_all("R5");
      end
    end

    // R6: abort discards, empty commit does nothing
    load_bytes(2, 1, 4, 90);
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    expect_idle(4, "R6 abort then commit");
    load_bytes(3, 0, 0, 91);
    commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    expect_idle(4, "R6 empty commit");
    sweep_all("R6");

    // R7 R9 R10: activity during the burn is ignored
    load_bytes(1, 6, 3, 92);
    commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    chk(busy === 1'b1, "R4 busy raised", int'(busy), 1);
    load_start = 1'b1; load_page = 3'd5; load_offset = 3'd0;
    @(negedge clk); load_start = 1'b0;
    byte_valid = 1'b1; byte_data = 8'h5A;
    @(negedge clk); byte_valid = 1'b0;
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    rd_en = 1'b1; rd_addr = 6'd0;
    @(negedge clk); rd_en = 1'b0;
    chk(rd_valid === 1'b0, "R9 read while busy", int'(rd_valid), 0);
    for (int o = 0; o < PB; o++) if (em[o]) model[PB + o] = eb[o];
    while (busy === 1'b1) @(negedge clk);
    commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    expect_idle(4, "R10 commit after burn");
    sweep_all("R7");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule